// File: doc/BRIEF.md
# Column-Parallel Ramp Converter Gray-Code Capture

This block forms the digital back end of a column-parallel single-slope analog-to-digital converter. A start pulse launches one conversion. A single shared counter then steps through every code of the converter's resolution, one code per clock, while an external ramp sweeps. The counter advances in Gray code, so exactly one of its bits toggles on each step. This keeps switching noise on the long count bus that runs across all columns low.

Each column has a comparator that compares its pixel level against the ramp, and its output is fed in asynchronously. A column passes its comparator through a synchronizer chain, detects the first rising edge, and freezes the shared Gray count at that moment. A column whose comparator never trips is given the full-scale code. Once the last code has been counted, every column converts its frozen Gray word to binary in one step. A valid flag then rises and stays high until the next conversion is accepted. No result register changes while the counter is running, so the readout logic stays quiet while the analog side is active.

Top module: `ramp_code_capture`

## Requirements
- R1: After reset, valid_o is 0 and every column result is 0.
- R2: A start_i sampled high while idle begins a conversion that counts codes 0 to 2^RES_BITS-1 over exactly 2^RES_BITS clocks. valid_o is still 0 one clock after the last count and is 1 on the clock after that.
- R3: While a conversion runs, each step of the shared count changes exactly one bit (Gray code).
- R4: Take the clock edge that accepts start as edge 0. If a column's comparator input first rises between edge j-1 and edge j, that column's binary result is j+1, limited to 2^RES_BITS-1. Column c's result occupies result_o[c*RES_BITS +: RES_BITS], and columns are independent.
- R5: A column whose comparator input never rises during a conversion reports full scale, 2^RES_BITS-1.
- R6: Only the first rising edge of a column's comparator within a conversion is captured. Later falls and rises of that comparator do not change its result.
- R7: result_o holds its previous value for the whole conversion and updates only when valid_o rises.
- R8: start_i asserted while a conversion is running is ignored. The running conversion's timing and results are unchanged.
- R9: valid_o falls on the clock edge that accepts a new start. It rises only two clocks after the clock in which the last code is held.

Top module parameters: N_COL (columns, default 4), RES_BITS (default 10), SYNC_STAGES (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-conversion request, honoured only when idle |
| cmp_i | input | N_COL | Asynchronous comparator output per column, rising when the ramp crosses the pixel level |
| result_o | output | N_COL*RES_BITS | Binary conversion results, column c at bits [c*RES_BITS +: RES_BITS] |
| valid_o | output | 1 | Results from the last finished conversion are valid |

## Verification
The bound checker watches the shared counter on every cycle. It checks that each step toggles exactly one bit, that a conversion ends only after the last code, that a start during a conversion does not disturb it, that result_o stays frozen while counting, and that valid_o rises two cycles after the last code and drops when a new start is accepted. The mapping from comparator crossing time to result code cannot be seen by a per-cycle property, because it depends on the synchronizer latency and the clamp at full scale. The same holds for full-scale fill-in, for ignoring comparator glitches after the first edge, and for independence between columns. Only the bench's conversions show these, by placing crossings at chosen cycles and comparing the decoded results.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   // Phases of the shared ramp counter
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_RAMP  = 2'd1,
      PH_FLUSH = 2'd2
   } ramp_phase_e;

   localparam int unsigned MAX_RES_BITS = 16;

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rcc_gray_ramp.sv
module rcc_gray_ramp #(
   parameter int unsigned RES_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic                launch_o,
   output logic                ramp_o,
   output logic                last_o,
   output logic                done_o,
   output logic [RES_BITS-1:0] gray_o
);

   import rcc_pkg::*;

   localparam int unsigned   STEPS   = 1 << RES_BITS;
   localparam logic [RES_BITS-1:0] TOP_CODE = RES_BITS'(STEPS - 1);

   ramp_phase_e         phase_q;
   logic [RES_BITS-1:0] bin_q;
   logic [RES_BITS-1:0] gray_q;
   logic [RES_BITS-1:0] bin_nx;
   logic [RES_BITS-1:0] gray_nx;

   assign bin_nx   = bin_q + 1'b1;
   assign gray_nx  = bin_nx ^ (bin_nx >> 1);
   assign launch_o = start_i && (phase_q == PH_IDLE);
   assign ramp_o   = (phase_q == PH_RAMP);
   assign last_o   = ramp_o && (bin_q == TOP_CODE);
   assign done_o   = (phase_q == PH_FLUSH);
   assign gray_o   = gray_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         bin_q   <= '0;
         gray_q  <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (launch_o) begin
                  phase_q <= PH_RAMP;
                  bin_q   <= '0;
                  gray_q  <= '0;
               end
            end
            PH_RAMP: begin
               if (bin_q == TOP_CODE) begin
                  phase_q <= PH_FLUSH;
                  bin_q   <= '0;
                  gray_q  <= '0;
               end else begin
                  bin_q   <= bin_nx;
                  gray_q  <= gray_nx;
               end
            end
            PH_FLUSH: phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/rcc_column.sv
module rcc_column #(
   parameter int unsigned RES_BITS    = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                launch_i,
   input  logic                ramp_i,
   input  logic                last_i,
   input  logic                done_i,
   input  logic [RES_BITS-1:0] gray_i,
   input  logic                cmp_i,
   output logic [RES_BITS-1:0] result_o
);

   logic                cmp_s;
   logic                cmp_d_q;
   logic                rise;
   logic                hit_q;
   logic [RES_BITS-1:0] frozen_q;
   logic [RES_BITS-1:0] decoded;
   logic [RES_BITS-1:0] result_q;

   rcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cmp_i),
      .q_o   (cmp_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_d_q <= 1'b0;
      else        cmp_d_q <= cmp_s;
   end

   assign rise = cmp_s && !cmp_d_q;

   // First edge wins; the last count fills in full scale for silent columns
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_q    <= 1'b0;
         frozen_q <= '0;
      end else if (launch_i) begin
         hit_q    <= 1'b0;
      end else if (ramp_i && !hit_q && (rise || last_i)) begin
         hit_q    <= 1'b1;
         frozen_q <= gray_i;
      end
   end

   // Gray to binary: each bit is the parity of the bits above and including it
   always_comb begin
      decoded[RES_BITS-1] = frozen_q[RES_BITS-1];
      for (int i = RES_BITS - 2; i >= 0; i--) begin
         decoded[i] = decoded[i+1] ^ frozen_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      result_q <= '0;
      else if (done_i) result_q <= decoded;
   end

   assign result_o = result_q;

endmodule

// File: rtl/ramp_code_capture.sv
module ramp_code_capture #(
   parameter int unsigned N_COL       = 4,
   parameter int unsigned RES_BITS    = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start_i,
   input  logic [N_COL-1:0]          cmp_i,
   output logic [N_COL*RES_BITS-1:0] result_o,
   output logic                      valid_o
);

   if (N_COL < 1) begin : g_bad_cols
      $error("ramp_code_capture: N_COL must be at least 1");
   end
   if (RES_BITS < 2 || RES_BITS > rcc_pkg::MAX_RES_BITS) begin : g_bad_res
      $error("ramp_code_capture: RES_BITS out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ramp_code_capture: SYNC_STAGES must be at least 2");
   end

   logic                cnt_launch;
   logic                cnt_ramp;
   logic                cnt_last;
   logic                cnt_done;
   logic [RES_BITS-1:0] cnt_gray;
   logic                valid_q;

   rcc_gray_ramp #(.RES_BITS(RES_BITS)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .launch_o (cnt_launch),
      .ramp_o   (cnt_ramp),
      .last_o   (cnt_last),
      .done_o   (cnt_done),
      .gray_o   (cnt_gray)
   );

   for (genvar c = 0; c < N_COL; c++) begin : g_col
      rcc_column #(
         .RES_BITS    (RES_BITS),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_col (
         .clk      (clk),
         .rst_n    (rst_n),
         .launch_i (cnt_launch),
         .ramp_i   (cnt_ramp),
         .last_i   (cnt_last),
         .done_i   (cnt_done),
         .gray_i   (cnt_gray),
         .cmp_i    (cmp_i[c]),
         .result_o (result_o[c*RES_BITS +: RES_BITS])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          valid_q <= 1'b0;
      else if (cnt_launch) valid_q <= 1'b0;
      else if (cnt_done)   valid_q <= 1'b1;
   end

   assign valid_o = valid_q;

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker #(
   parameter int unsigned N_COL    = 4,
   parameter int unsigned RES_BITS = 10
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      start_i,
   input logic                      ramp,
   input logic                      last,
   input logic [RES_BITS-1:0]       gray,
   input logic [N_COL*RES_BITS-1:0] result_o,
   input logic                      valid_o
);

   assert_gray_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp && $past(ramp)) |-> ($countones(gray ^ $past(gray)) == 1));

   assert_begin_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ramp && !$past(last)) |=> (ramp && gray == '0));

   assert_end_after_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ramp) |-> $past(last));

   assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ramp && !last) |=> ramp);

   assert_frozen_results_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ramp |-> $stable(result_o));

   assert_valid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ramp && !$past(last)) |=> !valid_o);

   assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(last, 2));

endmodule

bind ramp_code_capture rcc_checker #(
   .N_COL    (N_COL),
   .RES_BITS (RES_BITS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .ramp     (cnt_ramp),
   .last     (cnt_last),
   .gray     (cnt_gray),
   .result_o (result_o),
   .valid_o  (valid_o)
);

// File: tb/ramp_code_capture_test.sv
module ramp_code_capture_test;

   localparam int NC    = 4;
   localparam int RB    = 10;
   localparam int FULL  = (1 << RB) - 1;
   localparam int NEVER = 5000;
   localparam int NVEC  = 5;
   // Comparator crossing edge index per column, one row per conversion
   localparam int VEC [NVEC][NC] = '{
      '{0,     1,    500,  1022},
      '{NEVER, 7,    1023, NEVER},
      '{100,   100,  100,  100},
      '{3,     1021, 512,  255},
      '{NEVER, NEVER, 0,   2}
   };

   logic                clk = 1'b0;
   logic                rst_n;
   logic                start;
   logic [NC-1:0]       cmp;
   logic [NC*RB-1:0]    res;
   logic                valid;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int jt [NC];
   int prev_exp [NC];
   bit glitch;

   always #10 clk = ~clk;

   ramp_code_capture #(.N_COL(NC), .RES_BITS(RB), .SYNC_STAGES(2)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .cmp_i    (cmp),
      .result_o (res),
      .valid_o  (valid)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int code_for(input int j);
      return (j + 1 > FULL) ? FULL : j + 1;
   endfunction

   task automatic run_conv();
      @(negedge clk);
      start = 1'b1;
      for (int c = 0; c < NC; c++) if (jt[c] == 0) cmp[c] = 1'b1;
      for (int e = 1; e <= 1026; e++) begin
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         for (int c = 0; c < NC; c++) begin
            if (jt[c] == e) cmp[c] = 1'b1;
            if (glitch && jt[c] + 3 == e) cmp[c] = 1'b0;
            if (glitch && jt[c] + 6 == e) cmp[c] = 1'b1;
         end
         if (e - 1 == 0)   check("R9 valid cleared by start", int'(valid), 0);
         if (e - 1 == 300) start = 1'b1;   // R8: request while busy
         if (e - 1 == 500)
            for (int c = 0; c < NC; c++)
               check($sformatf("R7 col%0d held mid-conversion", c),
                     int'(res[c*RB +: RB]), prev_exp[c]);
         if (e - 1 == 1024) check("R2/R8 valid one clock after last code", int'(valid), 0);
         if (e - 1 == 1025) begin
            check("R2/R8 valid two clocks after last code", int'(valid), 1);
            for (int c = 0; c < NC; c++) begin
               int exp;
               exp = (jt[c] >= NEVER) ? FULL : code_for(jt[c]);
               check($sformatf("%s R3/R4 col%0d code", glitch ? "R6" :
                               (jt[c] >= NEVER ? "R5" : "R4"), c),
                     int'(res[c*RB +: RB]), exp);
               prev_exp[c] = exp;
            end
         end
      end
      cmp = '0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst_n  = 1'b0;
      start  = 1'b0;
      cmp    = '0;
      glitch = 1'b0;
      for (int c = 0; c < NC; c++) prev_exp[c] = 0;
      repeat (3) @(negedge clk);
      check("R1 valid at reset", int'(valid), 0);
      for (int c = 0; c < NC; c++)
         check($sformatf("R1 col%0d result at reset", c), int'(res[c*RB +: RB]), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         for (int c = 0; c < NC; c++) jt[c] = VEC[v][c];
         run_conv();
      end

      // R6: comparator drops and rises again after its first edge
      glitch = 1'b1;
      jt = '{10, 20, 30, NEVER};
      run_conv();
      glitch = 1'b0;

      // R5: silent conversion after a busy one, every column full scale
      jt = '{NEVER, NEVER, NEVER, NEVER};
      run_conv();

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule